// File: doc/BRIEF.md
# Split-Screen Address Reloader

This block divides the visible picture into an upper and a lower region, each fetched from its own memory origin. Software programs a split line number and a 16-bit alternate start address through a byte-wide register write port. The block watches the video timing (the visible scan-line count, a start-of-line pulse and vertical sync). When the chosen line has been displayed, it drives a one-cycle reload strobe and a reload value into the display memory-address counter. Lines above the split keep using the normal start address, which is handled elsewhere. Lines below the split run from the alternate origin, so the lower region can scroll independently of the upper one. Pixel scrolling and line scrolling still act on both regions. They are applied downstream and are not part of this block.

The alternate address is copied as one whole 16-bit value into a working register when a new frame begins. A write to only the high byte or only the low byte in the middle of a frame therefore cannot produce a half-updated origin. The reload happens at most once per frame, and the trigger rearms at the next frame start.

Top module: `splitReloader`

## Requirements
- R1: After reset the split line register and both address bytes are 0, `reloadStrobe` is low and `reloadAddr` is 0.
- R2: A split line value of 0 disables splitting: no reload strobe is produced in any frame.
- R3: If `lineStart` is high while `lineCount` equals a nonzero split line value, then `reloadStrobe` is high during the next `lineStart` cycle of the same frame, for exactly that cycle. During that cycle `reloadAddr` carries the address latched at the frame start. A split that is still pending when vertical sync rises is discarded.
- R4: At most one reload strobe occurs per frame, counted between rising edges of `vsync`. Each rising edge of `vsync` rearms the trigger.
- R5: `reloadAddr` changes only on a rising edge of `vsync`, when it takes the current {high byte, low byte} register pair. Writes made during a frame take effect together at the next frame start.
- R6: Register select codes: `regSel`=0 writes the split line, 1 writes the address high byte (`reloadAddr[15:8]`), 2 writes the low byte (`reloadAddr[7:0]`). Code 3 writes nothing.
- R7: No reload strobe occurs after reset until the first rising edge of `vsync` has been seen.
- R8: `reloadStrobe` is high only in cycles where `lineStart` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 2 | Register select (0 line, 1 address high, 2 address low, 3 none) |
| regWrData | input | 8 | Register write data |
| vsync | input | 1 | Vertical sync level; its rising edge starts a frame |
| lineStart | input | 1 | One-cycle pulse at the start of each scan line |
| lineCount | input | 8 | Visible scan-line number, valid while lineStart is high |
| reloadStrobe | output | 1 | Reload the display address counter this cycle |
| reloadAddr | output | 16 | Value to load into the display address counter |

## Verification
The assertions assume that `lineStart` is a single-cycle pulse and that `lineCount` is steady and meaningful while it is high. They also assume that `vsync` rises only between lines, never in the same cycle as `lineStart`. The stimulus drives every line as a one-cycle `lineStart` pulse followed by idle cycles. It raises and lowers `vsync` on separate cycles away from any line pulse, and it performs register writes only in idle cycles. Under these rules a strobe is tied to exactly one frame, so the once-per-frame and address-stability checks stay meaningful.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int REG_SEL_W = 2;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_LINE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;  // copy shadow address pair into working address
    logic fire;       // reload the display address counter now
  } ctlStrobes_t;
endpackage

// File: rtl/splitDatapath.sv
module splitDatapath
  import splitPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [DATA_W-1:0]     lineCount,
  input  ctlStrobes_t           strobes,
  output logic                  lineMatch,
  output logic [2*DATA_W-1:0]   activeAddr
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] splitLine;
  logic [DATA_W-1:0] addrHi;
  logic [DATA_W-1:0] addrLo;
  logic [ADDR_W-1:0] shadowAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitLine <= '0;
      addrHi    <= '0;
      addrLo    <= '0;
    end else if (regWrEn) begin
      unique case (regSel_e'(regSel))
        SEL_LINE: splitLine <= regWrData;
        SEL_HI:   addrHi    <= regWrData;
        SEL_LO:   addrLo    <= regWrData;
        default:  ;
      endcase
    end
  end

  assign shadowAddr = {addrHi, addrLo};

  always_ff @(posedge clk) begin
    if (!rstN)                  activeAddr <= '0;
    else if (strobes.latchAddr) activeAddr <= shadowAddr;
  end

  assign lineMatch = (splitLine != '0) && (lineCount == splitLine);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchAddr |=> $stable(activeAddr));

  // R5
  addr_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchAddr |=> (activeAddr == $past(shadowAddr)));
endmodule

// File: rtl/splitControl.sv
module splitControl
  import splitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vsync,
  input  logic        lineStart,
  input  logic        lineMatch,
  output ctlStrobes_t strobes
);
  logic vsyncQ;
  logic vsyncRise;
  logic armed;
  logic pending;

  assign vsyncRise = vsync && !vsyncQ;

  always_ff @(posedge clk) begin
    if (!rstN) vsyncQ <= 1'b0;
    else       vsyncQ <= vsync;
  end

  always_comb begin
    strobes.latchAddr = vsyncRise;
    strobes.fire      = lineStart && pending && armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      pending <= 1'b0;
    end else if (vsyncRise) begin
      armed   <= 1'b1;
      pending <= 1'b0;
    end else if (strobes.fire) begin
      armed   <= 1'b0;
      pending <= 1'b0;
    end else if (lineStart && armed && lineMatch) begin
      pending <= 1'b1;
    end
  end

  // checker state: one strobe per frame, and a frame seen since reset
  logic firedThisFrame;
  logic seenFrame;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      firedThisFrame <= 1'b0;
      seenFrame      <= 1'b0;
    end else begin
      if (vsyncRise) begin
        firedThisFrame <= 1'b0;
        seenFrame      <= 1'b1;
      end else if (strobes.fire) begin
        firedThisFrame <= 1'b1;
      end
    end
  end

  // R8
  strobe_on_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> lineStart);

  // R4
  once_per_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> !firedThisFrame);

  // R7
  no_fire_before_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> seenFrame);
endmodule

// File: rtl/splitReloader.sv
module splitReloader
  import splitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [7:0]  regWrData,
  input  logic        vsync,
  input  logic        lineStart,
  input  logic [7:0]  lineCount,
  output logic        reloadStrobe,
  output logic [15:0] reloadAddr
);
  localparam int DATA_W = 8;

  ctlStrobes_t strobes;
  logic        lineMatch;

  splitControl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .vsync     (vsync),
    .lineStart (lineStart),
    .lineMatch (lineMatch),
    .strobes   (strobes)
  );

  splitDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .lineCount  (lineCount),
    .strobes    (strobes),
    .lineMatch  (lineMatch),
    .activeAddr (reloadAddr)
  );

  assign reloadStrobe = strobes.fire;
endmodule

// File: tb/splitReloader_tb_top.sv
module splitReloader_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [7:0]  regWrData;
  logic        vsync;
  logic        lineStart;
  logic [7:0]  lineCount;
  logic        reloadStrobe;
  logic [15:0] reloadAddr;

  int checks = 0;
  int errors = 0;
  int strobeCount;
  int strobeLine;
  logic [15:0] strobeAddr;

  always #10 clk = ~clk;  // 50 MHz

  splitReloader dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseVsync();
    @(negedge clk); vsync = 1'b1;
    idle(2);
    vsync = 1'b0;
    idle(2);
  endtask

  // lines numbered (k % wrap) for k in 0..n-1; records strobes seen
  task automatic runLines(input int n, input int wrap);
    strobeCount = 0; strobeLine = -1; strobeAddr = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      lineStart = 1'b1; lineCount = 8'(k % wrap);
      #2;
      if (reloadStrobe) begin
        strobeCount++; strobeLine = k; strobeAddr = reloadAddr;
      end
      @(negedge clk);
      lineStart = 1'b0;
      #2;
      if (reloadStrobe) begin
        strobeCount++;
        check(1'b0, "R8 strobe without lineStart", 1, 0);
      end
      idle(2);
    end
  endtask

  task automatic t_reset();
    check(reloadStrobe == 1'b0, "R1 strobe", reloadStrobe, 0);
    check(reloadAddr == 16'h0, "R1 addr", reloadAddr, 0);
    writeReg(2'd0, 8'd2);
    runLines(6, 256);
    check(strobeCount == 0, "R7 no strobe before first frame", strobeCount, 0);
  endtask

  task automatic t_basic();
    writeReg(2'd0, 8'd5);
    writeReg(2'd1, 8'h12);
    writeReg(2'd2, 8'h34);
    pulseVsync();
    runLines(10, 256);
    check(strobeCount == 1, "R3 one strobe", strobeCount, 1);
    check(strobeLine == 6, "R3 strobe on line after split", strobeLine, 6);
    check(strobeAddr == 16'h1234, "R6 address byte order", strobeAddr, 16'h1234);
  endtask

  task automatic t_disable();
    writeReg(2'd0, 8'd0);
    pulseVsync();
    runLines(10, 256);
    check(strobeCount == 0, "R2 split line zero", strobeCount, 0);
  endtask

  task automatic t_once();
    writeReg(2'd0, 8'd3);
    pulseVsync();
    runLines(20, 8);
    check(strobeCount == 1, "R4 once per frame", strobeCount, 1);
    check(strobeLine == 4, "R4 first occurrence", strobeLine, 4);
    pulseVsync();
    runLines(20, 8);
    check(strobeCount == 1, "R4 rearm next frame", strobeCount, 1);
  endtask

  task automatic t_latch();
    writeReg(2'd0, 8'd2);
    pulseVsync();
    writeReg(2'd1, 8'hAB);  // mid-frame, high byte only
    check(reloadAddr == 16'h1234, "R5 mid-frame write held", reloadAddr, 16'h1234);
    runLines(6, 256);
    check(strobeAddr == 16'h1234, "R5 old address used", strobeAddr, 16'h1234);
    pulseVsync();
    runLines(6, 256);
    check(strobeAddr == 16'hAB34, "R5 new address next frame", strobeAddr, 16'hAB34);
  endtask

  task automatic t_selNone();
    writeReg(2'd3, 8'h77);
    pulseVsync();
    check(reloadAddr == 16'hAB34, "R6 select 3 ignored addr", reloadAddr, 16'hAB34);
    runLines(6, 256);
    check(strobeLine == 3, "R6 select 3 ignored line", strobeLine, 3);
  endtask

  task automatic t_lastLine();
    writeReg(2'd0, 8'd5);
    pulseVsync();
    runLines(6, 256);  // split on final line, no next line
    check(strobeCount == 0, "R3 no line after split", strobeCount, 0);
    pulseVsync();
    runLines(3, 256);
    check(strobeCount == 0, "R3 pending discarded at vsync", strobeCount, 0);
  endtask

  bit done = 1'b0;

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = '0; regWrData = '0;
    vsync = 1'b0; lineStart = 1'b0; lineCount = '0;
    idle(4);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_disable();
    t_once();
    t_latch();
    t_selNone();
    t_lastLine();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule